// File: doc/BRIEF.md
# Pseudo-Random Fill-and-Verify Memory Tester

This block runs a destructive go/no-go check on a range of a synchronous memory. On a start pulse it writes a pseudo-random word, produced by a linear feedback shift register (LFSR), to every address of the range from the lowest address to the highest. Only after that sweep ends does it go back to the lowest address. It then starts the generator again from the same seed, reads every location back, and compares each returned word with the regenerated one.

The whole write-then-read sequence runs once for each entry of a parameter list of seeds, in index order. Using several seeds makes a fault that slips past one sequence very unlikely to slip past them all. The run ends with a pass after the last seed. If any word differs it ends at once with a fail and a report of the failing address, the seed index, the expected word and the word observed. The memory port issues at most one access per cycle, and read data returns one cycle after the request.

Top module: `lfsr_fill_tester`

## Requirements
- R1: While reset is low and after it is released, busy, done, pass and fail are 0 and memEn is 0 until a start is accepted.
- R2: A start pulse is accepted only while busy is 0. In the cycle after acceptance, busy is 1, done, pass and fail are 0, and the first fill write goes to BASE_ADDR. A start pulse while busy is 1 has no effect on the access sequence.
- R3: The fill issues one write per cycle (memEn=1, memWe=1) at every address from BASE_ADDR to LAST_ADDR in ascending order. The word at BASE_ADDR is the seed. Each following word is the previous one shifted right by one, XORed with TAP_MASK when the shifted-out bit was 1.
- R4: A seed entry of zero is replaced by ZERO_SEED, so the first fill word for that seed is ZERO_SEED.
- R5: In the cycle after the last fill write, the verify phase begins. It issues one read per cycle (memEn=1, memWe=0) from BASE_ADDR to LAST_ADDR in ascending order, and compares the memRdata returned one cycle after each read with the sequence regenerated from the same seed.
- R6: After the last verify read there is exactly one cycle with memEn=0. Then the fill for the next seed index begins. Seed indices run 0, 1, and so on up to NUM_SEEDS-1, each being the DATA_W-bit slice of SEED_LIST at that index.
- R7: If no mismatch occurs, done=1 and pass=1 with busy=0 appear in the cycle after the idle cycle of the last seed. The flags hold, with no memory access, until the next accepted start.
- R8: In the cycle that holds the first mismatching read data, no access is issued. In the next cycle done=1 and fail=1. failAddr gives the address that was read, failSeed the seed index, failExp the regenerated word and failObs the returned word. All of these hold until the next accepted start.
- R9: pass and fail are never both 1. memWe is never 1 without memEn. Every access address lies within BASE_ADDR to LAST_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Finished on a mismatch |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failSeed | output | SIDX_W | Seed index of the first mismatch |
| failExp | output | DATA_W | Regenerated word at the mismatch |
| failObs | output | DATA_W | Returned word at the mismatch |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Access address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid one cycle after a read |

## Verification
A wrong generator state or a wrong address counter shows on the memory port in the same cycle. The first wrong write word or wrong address is therefore caught by the per-cycle comparison against the bench's own model of the access stream, long before any verdict. A fault in the expected-word pipeline or the compare shows one cycle later: either as a missing idle cycle and an early done, or as a pass where the faulty memory model demands a fail. Injected memory faults (a stuck bit, an inverted bit at the last address, an aliased address line) check that the fail fields name the exact address, seed and both words.

// File: rtl/lft_pkg.sv
package lft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_VERIFY,
    ST_DRAIN,
    ST_DONE
  } tstate_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSeed;
    logic nextSeed;
    logic loadSeed;
    logic stepLfsr;
    logic clrAddr;
    logic incAddr;
    logic issueWrite;
    logic issueRead;
    logic captureFail;
    logic clrFail;
  } strobe_t;

endpackage

// File: rtl/lft_datapath.sv
module lft_datapath
  import lft_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BASE_ADDR = 0,
  parameter int unsigned LAST_ADDR = 1023,
  parameter int unsigned NUM_SEEDS = 4,
  parameter logic [NUM_SEEDS*DATA_W-1:0] SEED_LIST = 64'h5EED_ACE1_B00F_0001,
  parameter logic [DATA_W-1:0] TAP_MASK  = 16'hB400,
  parameter logic [DATA_W-1:0] ZERO_SEED = 16'h0001,
  localparam int unsigned SIDX_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic              addrAtLast,
  output logic              seedAtLast,
  output logic              mismatch,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] failAddr,
  output logic [SIDX_W-1:0] failSeed,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST_ADDR);
  localparam logic [SIDX_W-1:0] LAST_SI = SIDX_W'(NUM_SEEDS - 1);

  // seed table with zero entries substituted
  logic [DATA_W-1:0] seedTab [NUM_SEEDS];
  for (genvar g = 0; g < NUM_SEEDS; g++) begin : g_seed
    localparam logic [DATA_W-1:0] RAW = SEED_LIST[g*DATA_W +: DATA_W];
    assign seedTab[g] = (RAW == '0) ? ZERO_SEED : RAW;
  end

  logic [DATA_W-1:0] lfsr;
  logic [DATA_W-1:0] lfsrNext;
  logic [ADDR_W-1:0] addr;
  logic [SIDX_W-1:0] seedIdx;
  logic [SIDX_W-1:0] seedIdxNxt;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendExp;

  // Galois step, right-shifting form
  assign lfsrNext = {1'b0, lfsr[DATA_W-1:1]} ^ (lfsr[0] ? TAP_MASK : '0);

  always_comb begin
    seedIdxNxt = seedIdx;
    if (strb.clrSeed)       seedIdxNxt = '0;
    else if (strb.nextSeed) seedIdxNxt = seedIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr    <= '0;
      seedIdx <= '0;
      addr    <= BASE_A;
    end else begin
      seedIdx <= seedIdxNxt;
      if (strb.loadSeed)      lfsr <= seedTab[seedIdxNxt];
      else if (strb.stepLfsr) lfsr <= lfsrNext;
      if (strb.clrAddr)       addr <= BASE_A;
      else if (strb.incAddr)  addr <= addr + 1'b1;
    end
  end

  // expected-word pipeline matching the one-cycle read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendExp   <= '0;
    end else begin
      pendValid <= strb.issueRead;
      if (strb.issueRead) begin
        pendAddr <= addr;
        pendExp  <= lfsr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failAddr <= '0;
      failSeed <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end else if (strb.captureFail) begin
      failAddr <= pendAddr;
      failSeed <= seedIdx;
      failExp  <= pendExp;
      failObs  <= memRdata;
    end else if (strb.clrFail) begin
      failAddr <= '0;
      failSeed <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end
  end

  assign mismatch   = pendValid && (memRdata != pendExp);
  assign addrAtLast = (addr == LAST_A);
  assign seedAtLast = (seedIdx == LAST_SI);

  assign memEn    = strb.issueWrite | strb.issueRead;
  assign memWe    = strb.issueWrite;
  assign memAddr  = addr;
  assign memWdata = lfsr;

endmodule

// File: rtl/lft_ctrl.sv
module lft_ctrl
  import lft_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    addrAtLast,
  input  logic    seedAtLast,
  input  logic    mismatch,
  output strobe_t strb,
  output logic    busy,
  output logic    done,
  output logic    pass,
  output logic    fail
);

  tstate_t state;
  tstate_t stateNxt;
  logic    passR;
  logic    failR;
  logic    setPass;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    setPass  = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strb.clrSeed  = 1'b1;
          strb.loadSeed = 1'b1;
          strb.clrAddr  = 1'b1;
          strb.clrFail  = 1'b1;
          stateNxt      = ST_FILL;
        end
      end
      ST_FILL: begin
        strb.issueWrite = 1'b1;
        if (addrAtLast) begin
          strb.loadSeed = 1'b1;
          strb.clrAddr  = 1'b1;
          stateNxt      = ST_VERIFY;
        end else begin
          strb.stepLfsr = 1'b1;
          strb.incAddr  = 1'b1;
        end
      end
      ST_VERIFY: begin
        if (mismatch) begin
          strb.captureFail = 1'b1;
          stateNxt         = ST_DONE;
        end else begin
          strb.issueRead = 1'b1;
          strb.stepLfsr  = 1'b1;
          if (addrAtLast) stateNxt = ST_DRAIN;
          else            strb.incAddr = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (mismatch) begin
          strb.captureFail = 1'b1;
          stateNxt         = ST_DONE;
        end else if (seedAtLast) begin
          setPass  = 1'b1;
          stateNxt = ST_DONE;
        end else begin
          strb.nextSeed = 1'b1;
          strb.loadSeed = 1'b1;
          strb.clrAddr  = 1'b1;
          stateNxt      = ST_FILL;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      passR <= 1'b0;
      failR <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strb.clrFail) begin
        passR <= 1'b0;
        failR <= 1'b0;
      end else begin
        if (strb.captureFail) failR <= 1'b1;
        if (setPass)          passR <= 1'b1;
      end
    end
  end

  assign busy = (state == ST_FILL) || (state == ST_VERIFY) || (state == ST_DRAIN);
  assign done = (state == ST_DONE);
  assign pass = passR;
  assign fail = failR;

endmodule

// File: rtl/lfsr_fill_tester.sv
module lfsr_fill_tester
  import lft_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BASE_ADDR = 0,
  parameter int unsigned LAST_ADDR = 1023,
  parameter int unsigned NUM_SEEDS = 4,
  parameter logic [NUM_SEEDS*DATA_W-1:0] SEED_LIST = 64'h5EED_ACE1_B00F_0001,
  parameter logic [DATA_W-1:0] TAP_MASK  = 16'hB400,
  parameter logic [DATA_W-1:0] ZERO_SEED = 16'h0001,
  localparam int unsigned SIDX_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [SIDX_W-1:0] failSeed,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  strobe_t strb;
  logic    addrAtLast;
  logic    seedAtLast;
  logic    mismatch;

  lft_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .addrAtLast (addrAtLast),
    .seedAtLast (seedAtLast),
    .mismatch   (mismatch),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail       (fail)
  );

  lft_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .LAST_ADDR (LAST_ADDR),
    .NUM_SEEDS (NUM_SEEDS),
    .SEED_LIST (SEED_LIST),
    .TAP_MASK  (TAP_MASK),
    .ZERO_SEED (ZERO_SEED)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .memRdata   (memRdata),
    .addrAtLast (addrAtLast),
    .seedAtLast (seedAtLast),
    .mismatch   (mismatch),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .failAddr   (failAddr),
    .failSeed   (failSeed),
    .failExp    (failExp),
    .failObs    (failObs)
  );

endmodule

// File: rtl/lft_checker.sv
module lft_checker #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_ADDR = 0,
  parameter int unsigned LAST_ADDR = 1023
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] failAddr,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done && !pass && !fail));

  assert_verify_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe && $past(memEn && memWe)) |-> (memAddr == BASE_A));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(pass) && $stable(fail) && !memEn));

  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> (fail && $stable(failAddr)));

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail) && !(busy && done));

  assert_we_en_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

  assert_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (memAddr >= BASE_A && memAddr <= LAST_A));

endmodule

bind lfsr_fill_tester lft_checker #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .LAST_ADDR (LAST_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .fail     (fail),
  .failAddr (failAddr),
  .memEn    (memEn),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/lfsr_fill_tester_tb.sv
module lfsr_fill_tester_tb;

  localparam int DW   = 16;
  localparam int AW   = 6;
  localparam int BASE = 4;
  localparam int LAST = 35;
  localparam int NS   = 4;
  localparam logic [NS*DW-1:0] SEEDS = 64'h0001_1234_ACE1_0000;
  localparam logic [DW-1:0] TAP = 16'hB400;
  localparam logic [DW-1:0] ZS  = 16'hC0DE;

  logic clk = 1'b0;
  logic rstN;
  logic start;
  logic busy, done, pass, fail;
  logic [AW-1:0] failAddr;
  logic [1:0]    failSeed;
  logic [DW-1:0] failExp, failObs;
  logic memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;

  always #4 clk = ~clk;

  lfsr_fill_tester #(
    .ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(BASE), .LAST_ADDR(LAST),
    .NUM_SEEDS(NS), .SEED_LIST(SEEDS), .TAP_MASK(TAP), .ZERO_SEED(ZS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .failAddr(failAddr), .failSeed(failSeed), .failExp(failExp), .failObs(failObs),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // memory model with injectable faults: 0 none, 1 stuck-1 bit, 2 inverted bit, 3 aliased line
  int faultMode = 0;
  int faultAddr = 0;
  int faultBit  = 0;
  logic [DW-1:0] mem    [64];
  logic [DW-1:0] refMem [64];

  function automatic int phys(int a);
    if (faultMode == 3) return a & ~(1 << faultBit);
    return a;
  endfunction

  function automatic logic [DW-1:0] rdFault(logic [DW-1:0] v, int a);
    logic [DW-1:0] r = v;
    if (faultMode == 1 && a == faultAddr) r[faultBit] = 1'b1;
    if (faultMode == 2 && a == faultAddr) r[faultBit] = ~r[faultBit];
    return r;
  endfunction

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[phys(int'(memAddr))] <= memWdata;
      else       memRdata <= rdFault(mem[phys(int'(memAddr))], int'(memAddr));
    end
  end

  function automatic logic [DW-1:0] step(logic [DW-1:0] x);
    logic [DW-1:0] y = x >> 1;
    if (x[0]) y = y ^ TAP;
    return y;
  endfunction

  typedef struct {
    bit      en;
    bit      we;
    int      addr;
    logic [DW-1:0] data;
  } op_t;

  op_t expQ[$];
  bit  expFail;
  int  expFAddr, expFSeed;
  logic [DW-1:0] expFExp, expFObs;

  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic buildModel();
    expQ.delete();
    expFail = 0;
    for (int s = 0; s < NS; s++) begin
      logic [DW-1:0] sd = SEEDS[s*DW +: DW];
      logic [DW-1:0] x;
      if (sd == '0) sd = ZS;
      x = sd;
      for (int a = BASE; a <= LAST; a++) begin
        expQ.push_back('{1, 1, a, x});
        refMem[phys(a)] = x;
        x = step(x);
      end
      x = sd;
      for (int a = BASE; a <= LAST; a++) begin
        logic [DW-1:0] obs = rdFault(refMem[phys(a)], a);
        expQ.push_back('{1, 0, a, '0});
        if (obs != x) begin
          expFail = 1; expFAddr = a; expFSeed = s; expFExp = x; expFObs = obs;
          expQ.push_back('{0, 0, 0, '0});
          return;
        end
        x = step(x);
      end
      expQ.push_back('{0, 0, 0, '0});
    end
  endtask

  task automatic runTest(string name, int pokeAt);
    int idx = 0;
    buildModel();
    @(negedge clk);
    start = 1'b1;
    while (expQ.size() > 0) begin
      op_t o = expQ.pop_front();
      @(negedge clk);
      start = (idx == pokeAt) ? 1'b1 : 1'b0;
      if (idx == 0) begin
        chk(busy && !done && !pass && !fail, "R2", {name, " accept"}, {busy, done, pass, fail}, 4'b1000);
        chk(memWdata == ZS, "R4", {name, " zero seed word"}, memWdata, ZS);
      end
      if (pokeAt >= 0 && idx == pokeAt + 2)
        chk(busy == 1'b1, "R2", {name, " start while busy"}, busy, 1);
      if (!o.en)
        chk(!memEn && busy, "R6", {name, " idle cycle"}, {memEn, busy}, 2'b01);
      else if (o.we)
        chk(memEn && memWe && int'(memAddr) == o.addr && memWdata == o.data && busy, "R3",
            {name, " fill write"}, {memEn, memWe, memAddr, memWdata}, {1'b1, 1'b1, AW'(o.addr), o.data});
      else
        chk(memEn && !memWe && int'(memAddr) == o.addr && busy, "R5",
            {name, " verify read"}, {memEn, memWe, memAddr}, {1'b1, 1'b0, AW'(o.addr)});
      idx++;
    end
    @(negedge clk);
    start = 1'b0;
    if (expFail) begin
      chk(done && fail && !pass && !busy, "R8", {name, " fail flags"}, {busy, done, pass, fail}, 4'b0101);
      chk(int'(failAddr) == expFAddr, "R8", {name, " failAddr"}, failAddr, expFAddr);
      chk(int'(failSeed) == expFSeed, "R8", {name, " failSeed"}, failSeed, expFSeed);
      chk(failExp == expFExp && failObs == expFObs, "R8", {name, " fail words"},
          {failExp, failObs}, {expFExp, expFObs});
    end else begin
      chk(done && pass && !fail && !busy, "R7", {name, " pass flags"}, {busy, done, pass, fail}, 4'b0110);
    end
    chk(!(pass && fail), "R9", {name, " flags exclusive"}, {pass, fail}, 0);
    repeat (3) @(negedge clk);
    chk(done && !memEn && pass == !expFail && fail == expFail, "R7", {name, " hold"},
        {done, memEn, pass, fail}, {1'b1, 1'b0, !expFail, expFail});
  endtask

  initial begin
    rstN  = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !memEn, "R1", "during reset",
        {busy, done, pass, fail, memEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !memEn, "R1", "after reset",
        {busy, done, pass, fail, memEn}, 0);

    faultMode = 0;
    runTest("clean", -1);
    faultMode = 0;
    runTest("clean restart with busy start", 100);
    faultMode = 1; faultAddr = 20; faultBit = 3;
    runTest("stuck bit", -1);
    faultMode = 2; faultAddr = LAST; faultBit = 0;
    runTest("last address flip", -1);
    faultMode = 3; faultBit = 1;
    runTest("aliased line", -1);
    faultMode = 0;
    runTest("clean after fail", -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule